// File: doc/BRIEF.md
# Ingress Header Check and Shim Insertion

This block sits at the receive side of a router port, between the link interface and the switch fabric. Each IP packet arrives as a stream of 32-bit words with start and end markers. Along with the first word comes the result of a route lookup made elsewhere: a hit flag, an output interface number, a stream identifier, a reserved-flow indication and an active-flow indication. The block holds the first five words of the packet, which make up the minimum IPv4 header. From them it checks the version and header length and looks for a broadcast or multicast destination. It then writes a two-word (8-byte) internal shim ahead of the packet.

The shim carries a stream identifier, a byte of reason flags, the interface the packet arrived on and the interface it should leave by. An interface number is 16 bits: a 10-bit physical port in bits 15:6 and a 6-bit sub-port in bits 5:0. With every output word the block also gives a connection ID. A packet with no flags goes to the fabric connection of its output port. A packet with any flag set goes to a fixed connection that leads to a local software processor for exception handling. The output follows a valid/ready handshake, and the input is held off while the shim is sent.

Top module: `ing_shim_insert`

## Requirements
- R1: Every packet leaves as two shim words and then all of its input words, unchanged and in order. `out_sop` is set on the first shim word only, and `out_eop` is set on the last packet word only. After the beat that carries `out_eop`, `out_valid` is low for the next cycle.
- R2: Shim word 1 is {input interface, output interface}. The input interface is {PORT_NUM (10 bits), sub-port sampled with the first input word}. The output interface is the lookup interface when the lookup hit, and zero when it missed.
- R3: Shim word 0 bits 31:16 hold the lookup stream identifier when the reserved indication is set, and zero when it is not. Bits 15:8 are zero.
- R4: Flag bit 0 (unknown type) of shim word 0 is set when the version field (word 0 bits 31:28) is not 4, or the header length field (bits 27:24) is below 5, or the packet has fewer than 5 words.
- R5: Flag bit 1 (options) is set when bit 0 is clear and the header length field is above 5.
- R6: Flag bit 2 (no route) is set when the lookup missed.
- R7: Flag bit 3 (active flow) is set when the active-flow indication was given.
- R8: Flag bit 4 (special destination) is set when the packet has at least 5 words and word 4 is all ones or has 4'hE in bits 31:28.
- R9: When all flags are clear, `out_conn` equals 64 plus the output physical port (output interface bits 15:6). Otherwise it equals EXC_CONN (63). It holds one value for the whole packet.
- R10: While `out_valid` is high and `out_ready` low, the output beat does not change. No input word is accepted while a shim word is offered.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Packet word, IP header first |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_spi | input | 6 | Arrival sub-port, sampled with the first word |
| lk_found | input | 1 | Route lookup hit, sampled with the first word |
| lk_vif | input | 16 | Lookup output interface {port, sub-port} |
| lk_sid | input | 16 | Lookup stream identifier |
| lk_reserved | input | 1 | Flow is reserved; stream identifier is valid |
| lk_active | input | 1 | Flow needs active processing |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Shim or packet word |
| out_sop | output | 1 | First shim word |
| out_eop | output | 1 | Last packet word |
| out_conn | output | 11 | Selected internal connection ID |

## Verification
The stall-hold assertion assumes that the input source follows the handshake: once `in_valid` is raised, the word and its markers stay the same until they are accepted. This matters because, after the header, output words come straight from the input. The assertions also assume well-formed framing: a first word while idle, and exactly one end marker per packet. The stimulus keeps within these rules by raising `in_valid` only between packet words of a prebuilt stream and holding each word until `in_ready` takes it. Random gaps on the input and random `out_ready` stalls then exercise both kinds of back-pressure against that stream.

// File: rtl/ing_shim_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the ingress shim inserter.
// Assumes 32-bit words and the fixed 5-word minimum IPv4 header.
package ing_shim_pkg;
    localparam int WORD_W    = 32;
    localparam int PN_W      = 10;
    localparam int SPI_W     = 6;
    localparam int VIF_W     = PN_W + SPI_W;
    localparam int SID_W     = 16;
    localparam int FLAG_W    = 8;
    localparam int HDR_WORDS = 5;
    localparam int IP_V4     = 4;
    localparam int IHL_MIN   = 5;

    // Reason flag positions inside shim word 0
    localparam int FL_UK = 0;
    localparam int FL_OP = 1;
    localparam int FL_NR = 2;
    localparam int FL_AF = 3;
    localparam int FL_DA = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SHIM0,
        ST_SHIM1,
        ST_DRAIN,
        ST_PASS
    } ing_state_t;

    typedef struct packed {
        logic             found;
        logic             active;
        logic             resv;
        logic [VIF_W-1:0] vif;
        logic [SID_W-1:0] sid;
    } lk_res_t;
endpackage

// File: rtl/ing_hdr_buf.sv
`timescale 1ns/1ps
// Header capture buffer: holds the first DEPTH words of the current packet.
// Assumes wr_first comes with the first word and that no more than DEPTH
// words are written before the next wr_first.
module ing_hdr_buf #(
    parameter int DEPTH = 5,
    parameter int W     = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_first,
    input  logic [W-1:0]     wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     words [DEPTH]
);
    // One register per slot; the slot matching the fill count takes the word
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && (wr_first ? (g == 0) : (cnt == CNT_W'(g))))
                words[g] <= wr_data;
        end
    end

    // Fill count: restarts at one on the first word, then grows
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= wr_first ? CNT_W'(1) : cnt + CNT_W'(1);
    end

    AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_first) |-> (cnt < CNT_W'(DEPTH))); // R1
endmodule

// File: rtl/ing_hdr_check.sv
`timescale 1ns/1ps
// Header checker: derives the header-related and lookup-related reason
// flags from the version/length byte, the destination word, the number of
// captured words and the latched lookup result. Purely combinational.
module ing_hdr_check
    import ing_shim_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [7:0]        ver_ihl,
    input  logic [WORD_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              found,
    input  logic              active,
    output logic [FLAG_W-1:0] flags
);
    logic       complete;
    logic [3:0] ver;
    logic [3:0] ihl;
    logic       uk;

    // Evaluate each reason independently and pack them into the flag byte
    always_comb begin
        complete = (cnt == CNT_W'(HDR_WORDS));
        ver      = ver_ihl[7:4];
        ihl      = ver_ihl[3:0];
        uk       = (ver != 4'(IP_V4)) || (ihl < 4'(IHL_MIN)) || !complete;
        flags        = '0;
        flags[FL_UK] = uk;
        flags[FL_OP] = !uk && (ihl > 4'(IHL_MIN));
        flags[FL_NR] = !found;
        flags[FL_AF] = active;
        flags[FL_DA] = complete && ((&dst) || (dst[WORD_W-1 -: 4] == 4'hE));
    end
endmodule

// File: rtl/ing_shim_fmt.sv
`timescale 1ns/1ps
// Shim formatter: builds the two shim words and the outgoing connection
// ID from the flags and the latched lookup result. Combinational.
module ing_shim_fmt
    import ing_shim_pkg::*;
#(
    parameter int PORT_NUM    = 3,
    parameter int EXC_CONN    = 63,
    parameter int FABRIC_BASE = 64,
    parameter int CONN_W      = 11
) (
    input  logic [FLAG_W-1:0] flags,
    input  lk_res_t           lk,
    input  logic [SPI_W-1:0]  spi,
    output logic [WORD_W-1:0] shim0,
    output logic [WORD_W-1:0] shim1,
    output logic [CONN_W-1:0] conn
);
    localparam int PAD_W = WORD_W - SID_W - FLAG_W;

    logic [VIF_W-1:0] out_vif;
    logic [VIF_W-1:0] in_vif;
    logic [SID_W-1:0] sid_f;

    // Assemble shim fields and choose fabric or exception connection
    always_comb begin
        out_vif = lk.found ? lk.vif : '0;
        in_vif  = {PN_W'(PORT_NUM), spi};
        sid_f   = lk.resv ? lk.sid : '0;
        shim0   = {sid_f, {PAD_W{1'b0}}, flags};
        shim1   = {in_vif, out_vif};
        if (flags == '0)
            conn = CONN_W'(FABRIC_BASE) + CONN_W'(out_vif[VIF_W-1 -: PN_W]);
        else
            conn = CONN_W'(EXC_CONN);
    end
endmodule

// File: rtl/ing_shim_insert.sv
`timescale 1ns/1ps
// Ingress shim inserter top. Captures the first header words of a packet,
// checks them, emits a two-word shim and then the packet, and gives the
// connection ID for every output beat. Assumes well-formed framing on the
// input and that the lookup result is valid with the first word.
module ing_shim_insert
    import ing_shim_pkg::*;
#(
    parameter int PORT_NUM    = 3,
    parameter int EXC_CONN    = 63,
    parameter int FABRIC_BASE = 64,
    parameter int CONN_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [5:0]        in_spi,
    input  logic              lk_found,
    input  logic [15:0]       lk_vif,
    input  logic [15:0]       lk_sid,
    input  logic              lk_reserved,
    input  logic              lk_active,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [CONN_W-1:0] out_conn
);
    localparam int CNT_W = $clog2(HDR_WORDS + 1);

    ing_state_t        st_q, st_d;
    lk_res_t           lk_q;
    logic [SPI_W-1:0]  spi_q;
    logic              ended_q;
    logic [CNT_W-1:0]  didx_q;
    logic              buf_we, buf_first;
    logic [CNT_W-1:0]  buf_cnt;
    logic [WORD_W-1:0] buf_words [HDR_WORDS];
    logic [FLAG_W-1:0] flags;
    logic [WORD_W-1:0] shim0, shim1;
    logic              drain_last;

    ing_hdr_buf #(.DEPTH(HDR_WORDS), .W(WORD_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_first (buf_first),
        .wr_data  (in_data),
        .cnt      (buf_cnt),
        .words    (buf_words)
    );

    ing_hdr_check #(.CNT_W(CNT_W)) u_chk (
        .ver_ihl (buf_words[0][WORD_W-1 -: 8]),
        .dst     (buf_words[HDR_WORDS-1]),
        .cnt     (buf_cnt),
        .found   (lk_q.found),
        .active  (lk_q.active),
        .flags   (flags)
    );

    ing_shim_fmt #(
        .PORT_NUM    (PORT_NUM),
        .EXC_CONN    (EXC_CONN),
        .FABRIC_BASE (FABRIC_BASE),
        .CONN_W      (CONN_W)
    ) u_fmt (
        .flags (flags),
        .lk    (lk_q),
        .spi   (spi_q),
        .shim0 (shim0),
        .shim1 (shim1),
        .conn  (out_conn)
    );

    assign drain_last = (didx_q == buf_cnt - CNT_W'(1));

    // Next state, handshakes and output word selection
    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        buf_we    = 1'b0;
        buf_first = 1'b0;
        case (st_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && in_sop) begin
                    buf_we    = 1'b1;
                    buf_first = 1'b1;
                    st_d      = in_eop ? ST_SHIM0 : ST_FILL;
                end
            end
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    buf_we = 1'b1;
                    if (in_eop || buf_cnt == CNT_W'(HDR_WORDS - 1))
                        st_d = ST_SHIM0;
                end
            end
            ST_SHIM0: begin
                out_valid = 1'b1;
                out_data  = shim0;
                out_sop   = 1'b1;
                if (out_ready) st_d = ST_SHIM1;
            end
            ST_SHIM1: begin
                out_valid = 1'b1;
                out_data  = shim1;
                if (out_ready) st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_data  = buf_words[didx_q];
                out_eop   = ended_q && drain_last;
                if (out_ready && drain_last)
                    st_d = ended_q ? ST_IDLE : ST_PASS;
            end
            ST_PASS: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
                out_eop   = in_eop;
                if (in_valid && out_ready && in_eop) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Latch lookup result, sub-port and early end at packet start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q    <= '0;
            spi_q   <= '0;
            ended_q <= 1'b0;
        end else if (buf_we && buf_first) begin
            lk_q    <= '{found: lk_found, active: lk_active, resv: lk_reserved,
                         vif: lk_vif, sid: lk_sid};
            spi_q   <= in_spi;
            ended_q <= in_eop;
        end else if (buf_we && in_eop) begin
            ended_q <= 1'b1;
        end
    end

    // Index of the next buffered word to send
    always_ff @(posedge clk) begin
        if (!rst_n)
            didx_q <= '0;
        else if (st_q == ST_SHIM1 && out_ready)
            didx_q <= '0;
        else if (st_q == ST_DRAIN && out_ready)
            didx_q <= didx_q + CNT_W'(1);
    end

    AST_EXC_CONN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && (out_data[FLAG_W-1:0] != '0)) |-> (out_conn == CONN_W'(EXC_CONN))); // R9
    AST_CONN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> $stable(out_conn)); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R10
    AST_SHIM_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> !in_ready); // R10
    AST_SHIM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_sop) |=> (out_valid && !out_sop && !out_eop)); // R1
    AST_IDLE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid); // R1
endmodule

// File: tb/sim_ing_shim_insert.sv
`timescale 1ns/1ps
module sim_ing_shim_insert;
    localparam int PORT  = 3;
    localparam int EXC   = 63;
    localparam int BASE  = 64;
    localparam int CW    = 11;
    localparam int MAXW  = 2048;
    localparam int WDOG  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic [5:0]  in_spi = '0;
    logic lk_found = 1'b0, lk_reserved = 1'b0, lk_active = 1'b0;
    logic [15:0] lk_vif = '0, lk_sid = '0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_sop, out_eop;
    logic [31:0] out_data;
    logic [CW-1:0] out_conn;

    always #10 clk = ~clk;

    ing_shim_insert #(.PORT_NUM(PORT), .EXC_CONN(EXC), .FABRIC_BASE(BASE), .CONN_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_spi(in_spi),
        .lk_found(lk_found), .lk_vif(lk_vif), .lk_sid(lk_sid),
        .lk_reserved(lk_reserved), .lk_active(lk_active),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_conn(out_conn)
    );

    // input stream
    logic [31:0] iw [MAXW];
    logic        isop [MAXW], ieop [MAXW], ifnd [MAXW], ires [MAXW], iact [MAXW];
    logic [5:0]  ispi [MAXW];
    logic [15:0] ivif [MAXW], isid [MAXW];
    int n_in = 0;
    // expected output stream
    logic [31:0]   ed [MAXW];
    logic          esop [MAXW], eeop [MAXW];
    logic [CW-1:0] econ [MAXW];
    int            ekind [MAXW];
    int n_exp = 0;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R4..R8 reference flags
    function automatic logic [7:0] ref_flags(input logic [31:0] w0, input logic [31:0] w4,
                                             input int len, input bit fnd, input bit act);
        logic [7:0] f;
        bit uk;
        f  = '0;
        uk = (w0[31:28] != 4'd4) || (w0[27:24] < 4'd5) || (len < 5);
        f[0] = uk;
        f[1] = !uk && (w0[27:24] > 4'd5);
        f[2] = !fnd;
        f[3] = act;
        f[4] = (len >= 5) && ((w4 == 32'hFFFF_FFFF) || (w4[31:28] == 4'hE));
        return f;
    endfunction

    task automatic add_pkt(input int len, input logic [31:0] w0, input logic [31:0] w4,
                           input bit fnd, input bit act, input bit res,
                           input logic [15:0] vif, input logic [15:0] sid, input logic [5:0] spi);
        logic [7:0]    f;
        logic [15:0]   ovif;
        logic [CW-1:0] cn;
        f    = ref_flags(w0, w4, len, fnd, act);
        ovif = fnd ? vif : 16'h0;
        cn   = (f == 8'h0) ? CW'(BASE + int'(ovif[15:6])) : CW'(EXC);
        ed[n_exp] = {(res ? sid : 16'h0), 8'h00, f};
        esop[n_exp] = 1; eeop[n_exp] = 0; econ[n_exp] = cn; ekind[n_exp] = 0; n_exp++;
        ed[n_exp] = {10'(PORT), spi, ovif};
        esop[n_exp] = 0; eeop[n_exp] = 0; econ[n_exp] = cn; ekind[n_exp] = 1; n_exp++;
        for (int k = 0; k < len; k++) begin
            logic [31:0] w;
            w = (k == 0) ? w0 : (k == 4) ? w4 : $urandom;
            iw[n_in] = w; isop[n_in] = (k == 0); ieop[n_in] = (k == len - 1);
            ifnd[n_in] = fnd; ires[n_in] = res; iact[n_in] = act;
            ispi[n_in] = spi; ivif[n_in] = vif; isid[n_in] = sid; n_in++;
            ed[n_exp] = w; esop[n_exp] = 0; eeop[n_exp] = (k == len - 1);
            econ[n_exp] = cn; ekind[n_exp] = 2; n_exp++;
        end
    endtask

    initial begin
        int   iptr, eptr, cyc;
        bit   pres, pstall, psop, peop;
        logic [31:0] pdat;
        void'($urandom(32'd1234));
        // directed corner cases
        add_pkt(5, 32'h4500_0054, 32'h0A00_0001, 1, 0, 1, {10'd7, 6'd2}, 16'hBEEF, 6'd1);   // R9 fabric
        add_pkt(1, 32'h4500_0054, 32'h0, 1, 0, 0, 16'h0100, 16'h1, 6'd2);                  // R4 short
        add_pkt(4, 32'h4500_0054, 32'h0, 1, 0, 0, 16'h0100, 16'h1, 6'd3);                  // R4 short
        add_pkt(8, 32'h6500_0054, 32'h0A00_0002, 1, 0, 0, 16'h0100, 16'h1, 6'd4);          // R4 version
        add_pkt(8, 32'h4600_0054, 32'h0A00_0003, 1, 0, 0, 16'h0100, 16'h1, 6'd5);          // R5 options
        add_pkt(6, 32'h4400_0054, 32'h0A00_0004, 1, 0, 0, 16'h0100, 16'h1, 6'd6);          // R4 ihl<5
        add_pkt(7, 32'h4500_0054, 32'h0A00_0005, 0, 0, 1, 16'h1234, 16'h2, 6'd7);          // R6 R2
        add_pkt(6, 32'h4500_0054, 32'h0A00_0006, 1, 1, 0, 16'h0140, 16'h3, 6'd8);          // R7
        add_pkt(5, 32'h4500_0054, 32'hFFFF_FFFF, 1, 0, 0, 16'h0140, 16'h4, 6'd9);          // R8 bcast
        add_pkt(9, 32'h4500_0054, 32'hE000_0005, 1, 0, 0, 16'h0140, 16'h5, 6'd10);         // R8 mcast
        add_pkt(6, 32'h4500_0054, 32'h0A00_0007, 1, 0, 0, 16'h0180, 16'hCAFE, 6'd11);      // R3 unreserved
        add_pkt(5, 32'h4500_0054, 32'h0A00_0008, 1, 0, 1, 16'hFFFF, 16'h7777, 6'd63);      // R9 top port
        for (int p = 0; p < 60; p++) begin
            logic [3:0]  ver, ihl;
            logic [31:0] w4;
            int len;
            ver = ($urandom % 10 < 8) ? 4'd4 : 4'($urandom);
            ihl = ($urandom % 10 < 7) ? 4'd5 : 4'($urandom);
            len = ($urandom % 8 == 0) ? 1 + int'($urandom % 4) : 5 + int'($urandom % 8);
            case ($urandom % 8)
                0: w4 = 32'hFFFF_FFFF;
                1: w4 = {4'hE, 28'($urandom)};
                default: w4 = $urandom;
            endcase
            add_pkt(len, {ver, ihl, 24'($urandom)}, w4, ($urandom % 4) != 0, ($urandom % 8) == 0,
                    ($urandom % 3) == 0, 16'($urandom), 16'($urandom), 6'($urandom));
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid, "R11 out_valid", 32'(out_valid), 32'd0);
        chk(in_ready, "R11 in_ready", 32'(in_ready), 32'd1);

        iptr = 0; eptr = 0; cyc = 0; pres = 0; pstall = 0;
        psop = 0; peop = 0; pdat = '0;
        while (eptr < n_exp && cyc < WDOG) begin
            @(negedge clk);
            cyc++;
            if (!pres && iptr < n_in && ($urandom % 10) < 7) pres = 1;
            in_valid = pres;
            if (pres) begin
                in_data = iw[iptr]; in_sop = isop[iptr]; in_eop = ieop[iptr];
                in_spi = ispi[iptr]; lk_found = ifnd[iptr]; lk_vif = ivif[iptr];
                lk_sid = isid[iptr]; lk_reserved = ires[iptr]; lk_active = iact[iptr];
            end
            out_ready = ($urandom % 4) != 0;
            #1;
            if (pstall)
                chk(out_valid && out_data == pdat && out_sop == psop && out_eop == peop,
                    "R10 hold", out_data, pdat);
            pstall = out_valid && !out_ready;
            pdat = out_data; psop = out_sop; peop = out_eop;
            if (out_valid && out_ready) begin
                if (ekind[eptr] == 0) begin
                    chk(out_data[31:16] == ed[eptr][31:16], "R3 sid", out_data, ed[eptr]);
                    chk(out_data[15:8] == 8'h0, "R3 pad", out_data, ed[eptr]);
                    chk(out_data[0] == ed[eptr][0], "R4 flag", out_data, ed[eptr]);
                    chk(out_data[1] == ed[eptr][1], "R5 flag", out_data, ed[eptr]);
                    chk(out_data[2] == ed[eptr][2], "R6 flag", out_data, ed[eptr]);
                    chk(out_data[3] == ed[eptr][3], "R7 flag", out_data, ed[eptr]);
                    chk(out_data[7:4] == ed[eptr][7:4], "R8 flag", out_data, ed[eptr]);
                end else if (ekind[eptr] == 1) begin
                    chk(out_data == ed[eptr], "R2 vif", out_data, ed[eptr]);
                end else begin
                    chk(out_data == ed[eptr], "R1 data", out_data, ed[eptr]);
                end
                if (ekind[eptr] < 2)
                    chk(!in_ready, "R10 input held", 32'(in_ready), 32'd0);
                chk(out_sop == esop[eptr] && out_eop == eeop[eptr], "R1 markers",
                    {30'd0, out_sop, out_eop}, {30'd0, esop[eptr], eeop[eptr]});
                chk(out_conn == econ[eptr], "R9 conn", 32'(out_conn), 32'(econ[eptr]));
                eptr++;
            end
            if (pres && in_ready) begin
                iptr++;
                pres = 0;
            end
        end
        if (eptr < n_exp)
            chk(0, "R1 watchdog", 32'(eptr), 32'(n_exp));
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R1 idle at end", 32'(out_valid), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule